// File: doc/BRIEF.md
# Colour Lookup Table with Sequenced Byte Port

This block is a colour lookup table with 256 entries. Each entry holds a red, a green and a blue intensity of 6 bits. Software reaches the table through a narrow byte port of four registers. One register selects the entry where writing starts and another selects the entry where reading starts. A data register carries the colour bytes, and a mask register filters the pixel index. Software loads the table by setting the write index and then streaming bytes into the data register in red, green, blue order. After every blue byte the index moves on by itself. Readback works the same way through the read index.

The display pipeline drives a wide pixel word. The top bits of that word, ANDed with the mask register, pick an entry. The three components of that entry appear on registered outputs one clock later. An entry in the table changes only when its blue byte arrives, so a sequence that is broken off before blue leaves the table untouched.

Top module: `palette_lut`

## Requirements
- R1: While `rst` is high and after it falls, both index registers read 0, the mask register reads 0xFF, both component phases restart at red, and all three pixel outputs are 0.
- R2: A write to register address 0 (write index) sets the write entry to the written byte and restarts the write phase at red. A read of address 0 returns the current write entry.
- R3: Writes to address 2 (data) fill red, green and blue of the write entry in that order. The entry is stored when the blue byte is written, and the write entry then increments by one.
- R4: The write entry wraps from 255 to 0, so 768 data writes that start at entry 0 leave the write index reading 0.
- R5: A write to address 1 (read index) sets the read entry and restarts the read phase at red. Reads of address 2 then return red, green and blue of that entry, and the read entry increments after blue, wrapping from 255 to 0. Read data appears on `cpu_rdata` in the cycle after the read strobe.
- R6: Only bits 5:0 of each written data byte are stored. Data reads return bits 7:6 as zero.
- R7: Address 3 holds the pixel mask and reads back as written. The pixel index is the mask ANDed with the top bits of `pix_data`, so 0xFF leaves the index unchanged. A new mask value applies from the cycle after the write.
- R8: The entry chosen by bits 23:16 of `pix_data` (masked) appears on `pix_red`, `pix_green` and `pix_blue` one clock after it is sampled.
- R9: If a blue byte completes an entry in the same cycle that the pixel side looks that entry up, the pixel outputs show the old contents. The new contents show from the next lookup.
- R10: Loading either index while its sequence is partway through drops the bytes already given. A write sequence cut off this way leaves the table entry unchanged.
- R11: When `cpu_we` and `cpu_re` are high together, only the write takes place. The read cursor does not move and `cpu_rdata` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_re | input | 1 | Register read strobe |
| cpu_addr | input | 2 | Register select: 0 write index, 1 read index, 2 data, 3 mask |
| cpu_wdata | input | 8 | Write byte |
| cpu_rdata | output | 8 | Read byte, valid the cycle after `cpu_re` |
| pix_data | input | 24 | Pixel word; top 8 bits form the index |
| pix_red | output | 6 | Red of looked-up entry |
| pix_green | output | 6 | Green of looked-up entry |
| pix_blue | output | 6 | Blue of looked-up entry |

## Verification
The CPU read byte is due one clock after the read strobe, and the pixel components are due one clock after `pix_data` is sampled. A table entry changes at the clock edge of its blue byte, so a lookup of that entry in the same cycle still sees the old contents. The bench reference model works out both results at each rising edge from the state it held before that edge. It compares them at the next falling edge, when the registered outputs have settled. Pixel outputs are compared only once the model has a known value for the entry in question, or during reset, when they must be zero.

// File: rtl/pal_pkg.sv
package pal_pkg;
  typedef enum logic [1:0] {
    SEL_WIDX = 2'd0,
    SEL_RIDX = 2'd1,
    SEL_DATA = 2'd2,
    SEL_MASK = 2'd3
  } reg_sel_e;

  localparam logic [1:0] PH_RED = 2'd0;
  localparam logic [1:0] PH_GRN = 2'd1;
  localparam logic [1:0] PH_BLU = 2'd2;
  localparam int unsigned NUM_COMP = 3;
endpackage

// File: rtl/pal_cursor.sv
module pal_cursor #(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [IDX_W-1:0] load_idx,
  input  logic             step,
  output logic [IDX_W-1:0] idx,
  output logic [1:0]       phase
);
  import pal_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx   <= '0;
      phase <= PH_RED;
    end else if (load) begin
      idx   <= load_idx;
      phase <= PH_RED;
    end else if (step) begin
      if (phase == PH_BLU) begin
        phase <= PH_RED;
        idx   <= idx + 1'b1;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    phase != 2'd3); // R3

  AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (rst)
    load |=> (phase == PH_RED) && (idx == $past(load_idx))); // R10

  AST_STEP_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step && !load && phase == PH_BLU) |=>
      (idx == IDX_W'($past(idx) + 1'b1)) && (phase == PH_RED)); // R4

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!step && !load) |=> $stable(idx) && $stable(phase)); // R11
endmodule

// File: rtl/pal_store.sv
module pal_store #(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned COMP_W = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [IDX_W-1:0]    waddr,
  input  logic [3*COMP_W-1:0] wword,
  input  logic                cre,
  input  logic [IDX_W-1:0]    craddr,
  input  logic [1:0]          crsel,
  output logic [COMP_W-1:0]   crdata,
  input  logic [IDX_W-1:0]    paddr,
  output logic [3*COMP_W-1:0] pword
);
  import pal_pkg::*;

  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [COMP_W-1:0] cq [NUM_COMP];
  logic [COMP_W-1:0] pq [NUM_COMP];
  logic [1:0]        crsel_q;

  for (genvar g = 0; g < NUM_COMP; g++) begin : g_bank
    logic [COMP_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wword[g*COMP_W +: COMP_W];
      if (cre) cq[g] <= mem[craddr];
    end

    always_ff @(posedge clk) begin
      if (rst) pq[g] <= '0;
      else     pq[g] <= mem[paddr];
    end

    assign pword[g*COMP_W +: COMP_W] = pq[g];
  end

  always_ff @(posedge clk) begin
    if (rst)      crsel_q <= PH_RED;
    else if (cre) crsel_q <= crsel;
  end

  always_comb begin
    unique case (crsel_q)
      PH_GRN:  crdata = cq[1];
      PH_BLU:  crdata = cq[2];
      default: crdata = cq[0];
    endcase
  end

  AST_RSEL_LEGAL: assert property (@(posedge clk) disable iff (rst)
    cre |-> crsel != 2'd3); // R5
endmodule

// File: rtl/palette_lut.sv
module palette_lut #(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned COMP_W = 6,
  parameter int unsigned BUS_W  = 8,
  parameter int unsigned PIX_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_we,
  input  logic              cpu_re,
  input  logic [1:0]        cpu_addr,
  input  logic [BUS_W-1:0]  cpu_wdata,
  output logic [BUS_W-1:0]  cpu_rdata,
  input  logic [PIX_W-1:0]  pix_data,
  output logic [COMP_W-1:0] pix_red,
  output logic [COMP_W-1:0] pix_green,
  output logic [COMP_W-1:0] pix_blue
);
  import pal_pkg::*;

  localparam int unsigned WORD_W = 3 * COMP_W;

  reg_sel_e          sel;
  logic              rd_acc;
  logic              widx_load, ridx_load, data_wr, data_rd, commit;
  logic [IDX_W-1:0]  w_idx, r_idx, pix_idx;
  logic [1:0]        w_phase, r_phase;
  logic [COMP_W-1:0] stage_r, stage_g;
  logic [WORD_W-1:0] wword, pword;
  logic [IDX_W-1:0]  mask_q;
  logic [COMP_W-1:0] crdata;
  logic              rd_is_data_q;
  logic [BUS_W-1:0]  misc_q;

  assign sel       = reg_sel_e'(cpu_addr);
  assign rd_acc    = cpu_re && !cpu_we;
  assign widx_load = cpu_we && (sel == SEL_WIDX);
  assign ridx_load = cpu_we && (sel == SEL_RIDX);
  assign data_wr   = cpu_we && (sel == SEL_DATA);
  assign data_rd   = rd_acc && (sel == SEL_DATA);
  assign commit    = data_wr && (w_phase == PH_BLU);
  assign wword     = {cpu_wdata[COMP_W-1:0], stage_g, stage_r};
  assign pix_idx   = pix_data[PIX_W-1 -: IDX_W] & mask_q;

  pal_cursor #(.IDX_W(IDX_W)) u_wcur (
    .clk(clk), .rst(rst), .load(widx_load), .load_idx(cpu_wdata[IDX_W-1:0]),
    .step(data_wr), .idx(w_idx), .phase(w_phase)
  );

  pal_cursor #(.IDX_W(IDX_W)) u_rcur (
    .clk(clk), .rst(rst), .load(ridx_load), .load_idx(cpu_wdata[IDX_W-1:0]),
    .step(data_rd), .idx(r_idx), .phase(r_phase)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_r <= '0;
      stage_g <= '0;
    end else if (data_wr) begin
      if (w_phase == PH_RED) stage_r <= cpu_wdata[COMP_W-1:0];
      if (w_phase == PH_GRN) stage_g <= cpu_wdata[COMP_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                            mask_q <= '1;
    else if (cpu_we && sel == SEL_MASK) mask_q <= cpu_wdata[IDX_W-1:0];
  end

  pal_store #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_store (
    .clk(clk), .rst(rst), .we(commit), .waddr(w_idx), .wword(wword),
    .cre(data_rd), .craddr(r_idx), .crsel(r_phase), .crdata(crdata),
    .paddr(pix_idx), .pword(pword)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_is_data_q <= 1'b0;
      misc_q       <= '0;
    end else if (rd_acc) begin
      rd_is_data_q <= (sel == SEL_DATA);
      unique case (sel)
        SEL_WIDX: misc_q <= BUS_W'(w_idx);
        SEL_RIDX: misc_q <= BUS_W'(r_idx);
        SEL_MASK: misc_q <= BUS_W'(mask_q);
        default:  misc_q <= '0;
      endcase
    end
  end

  assign cpu_rdata = rd_is_data_q ? BUS_W'(crdata) : misc_q;
  assign pix_red   = pword[0 +: COMP_W];
  assign pix_green = pword[COMP_W +: COMP_W];
  assign pix_blue  = pword[2*COMP_W +: COMP_W];

  AST_DATA_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(data_rd) |-> cpu_rdata[BUS_W-1:COMP_W] == '0); // R6

  AST_MASK_READBACK: assert property (@(posedge clk) disable iff (rst)
    (cpu_we && sel == SEL_MASK) |=> mask_q == $past(cpu_wdata[IDX_W-1:0])); // R7

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!cpu_re || cpu_we) |=> $stable(cpu_rdata)); // R11

  AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !data_wr |=> $stable(stage_r) && $stable(stage_g)); // R10
endmodule

// File: tb/tb_palette_lut.sv
module tb_palette_lut;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpu_we = 1'b0, cpu_re = 1'b0;
  logic [1:0] cpu_addr = 2'd0;
  logic [7:0] cpu_wdata = 8'd0;
  logic [7:0] cpu_rdata;
  logic [23:0] pix_data = 24'd0;
  logic [5:0] pix_red, pix_green, pix_blue;

  always #(CLK_PERIOD/2) clk = ~clk;

  palette_lut dut (
    .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_re(cpu_re), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .pix_data(pix_data),
    .pix_red(pix_red), .pix_green(pix_green), .pix_blue(pix_blue)
  );

  int total = 0, bad = 0;
  bit done = 0;
  string rd_tag = "R1", pix_tag = "R1";

  // reference model state
  logic [7:0] m_widx, m_ridx, m_mask;
  int         m_wph, m_rph;
  logic [5:0] m_sr, m_sg;
  logic [5:0] mr [256], mg [256], mb [256];
  bit         known [256];
  bit         chk_rd, chk_pix;
  logic [7:0] exp_rd;
  logic [17:0] exp_pix;
  string      exp_rd_tag, exp_pix_tag;

  initial for (int i = 0; i < 256; i++) known[i] = 0;

  always @(posedge clk) begin
    logic [7:0] pi;
    exp_rd_tag  = rd_tag;
    exp_pix_tag = pix_tag;
    if (rst) begin
      m_widx = 0; m_ridx = 0; m_mask = 8'hFF; m_wph = 0; m_rph = 0;
      chk_rd = 0; chk_pix = 1; exp_pix = '0;
    end else begin
      pi = pix_data[23:16] & m_mask;
      chk_pix = known[pi];
      exp_pix = {mb[pi], mg[pi], mr[pi]};
      chk_rd = 0;
      if (cpu_we) begin
        case (cpu_addr)
          2'd0: begin m_widx = cpu_wdata; m_wph = 0; end
          2'd1: begin m_ridx = cpu_wdata; m_rph = 0; end
          2'd3: m_mask = cpu_wdata;
          default: begin
            if (m_wph == 0) m_sr = cpu_wdata[5:0];
            else if (m_wph == 1) m_sg = cpu_wdata[5:0];
            else begin
              mr[m_widx] = m_sr; mg[m_widx] = m_sg; mb[m_widx] = cpu_wdata[5:0];
              known[m_widx] = 1;
              m_widx = m_widx + 8'd1;
            end
            m_wph = (m_wph + 1) % 3;
          end
        endcase
      end else if (cpu_re) begin
        chk_rd = 1;
        case (cpu_addr)
          2'd0: exp_rd = m_widx;
          2'd1: exp_rd = m_ridx;
          2'd3: exp_rd = m_mask;
          default: begin
            exp_rd = {2'b00, (m_rph == 0) ? mr[m_ridx] : (m_rph == 1) ? mg[m_ridx] : mb[m_ridx]};
            if (m_rph == 2) m_ridx = m_ridx + 8'd1;
            m_rph = (m_rph + 1) % 3;
          end
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (chk_rd) begin
      total++;
      if (cpu_rdata !== exp_rd) begin
        bad++;
        $display("FAIL %s cpu_rdata actual=%h expected=%h", exp_rd_tag, cpu_rdata, exp_rd);
      end
    end
    if (chk_pix) begin
      total++;
      if ({pix_blue, pix_green, pix_red} !== exp_pix) begin
        bad++;
        $display("FAIL %s pixel actual=%h expected=%h", exp_pix_tag,
                 {pix_blue, pix_green, pix_red}, exp_pix);
      end
    end
  end

  task automatic cyc(input bit we, input bit re, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_we = we; cpu_re = re; cpu_addr = a; cpu_wdata = d;
  endtask
  task automatic wr(input logic [1:0] a, input logic [7:0] d); cyc(1, 0, a, d); endtask
  task automatic rd(input logic [1:0] a); cyc(0, 1, a, 8'd0); endtask
  task automatic idle(); cyc(0, 0, 2'd0, 8'd0); endtask

  initial begin
    rst_tags_r1: begin rd_tag = "R1"; pix_tag = "R1"; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    rd(0); rd(1); rd(3); idle();

    // R3 fill the table, high bits set on some bytes (R6)
    rd_tag = "R3"; pix_tag = "R8";
    wr(0, 8'd0);
    for (int i = 0; i < 256; i++) begin
      wr(2, 8'hC0 | 8'(i % 64));
      wr(2, 8'((i * 5 + 7) % 64));
      wr(2, 8'((255 - i) % 64) | ((i % 2 == 1) ? 8'h40 : 8'h00));
    end
    rd_tag = "R4"; rd(0); idle();

    // R5 readback across wrap, R6 high bits zero
    rd_tag = "R5/R6";
    wr(1, 8'd250);
    for (int i = 0; i < 30; i++) rd(2);
    rd(1); idle();

    // R2 write index load and readback
    rd_tag = "R2";
    wr(0, 8'd100); wr(2, 8'h11); wr(2, 8'h22); wr(2, 8'h33);
    rd(0); wr(1, 8'd100); rd(2); rd(2); rd(2); idle();

    // R10 partial sequence dropped
    rd_tag = "R10";
    wr(0, 8'd40); wr(2, 8'h3F); wr(2, 8'h3E); wr(0, 8'd40);
    rd(0); wr(1, 8'd41); rd(2); wr(1, 8'd40); rd(2); rd(2); rd(2); idle();

    // R11 simultaneous strobes: only the write happens
    rd_tag = "R11";
    wr(1, 8'd7); rd(2); cyc(1, 1, 2'd3, 8'hFF); rd(2); rd(1); idle();

    // R7 mask
    rd_tag = "R7"; pix_tag = "R7";
    wr(3, 8'h0F); rd(3);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); pix_data = {8'(i * 13 + 200), 16'hA5A5};
    end
    wr(3, 8'hFF); rd(3); idle();

    // R8 pixel sweep
    pix_tag = "R8";
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); pix_data = {8'(i * 37), 8'(i), 8'(255 - i)};
    end

    // R9 collision: lookup of the entry being completed
    pix_tag = "R9";
    wr(0, 8'd20); wr(2, 8'h01); wr(2, 8'h02);
    pix_data = {8'd20, 16'h0};
    wr(2, 8'h03);
    idle(); idle(); idle();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule